// File: doc/BRIEF.md
# Dual-Type Adder, Subtractor and Comparator

This block is a 10-bit arithmetic unit that serves two interpretations of the same bit patterns. A type select chooses between unsigned binary (0 to 1023) and two's-complement integers (-512 to +511). Two sections work side by side on the same pair of operands. A magnitude comparator reports greater, equal or less. An adder/subtractor forms the sum or the difference together with status flags. Flags that carry no meaning for the chosen type are held low.

Signed ordering comes from the unsigned comparator: both operand sign bits are inverted when the signed type is selected. Subtraction adds the inverted second operand with a carry-in of one. Parameters select the adder's internal structure (lookahead groups or a ripple chain) and the comparator's internal structure (grouped cells or a bit ripple). Every choice gives the same results. All outputs are registered once, and the register has a synchronous active-high reset.

Top module: `dtype_arith_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs become `res`=0, `cb`=0, `ovf`=0, `gt`=0, `lt`=0 and `eq`=1.
- R2: Inputs are sampled at a rising edge, and the matching outputs appear after that edge. The outputs do not change between edges.
- R3: `res` equals (opa + opb) mod 1024 when `op_sub`=0 and (opa - opb) mod 1024 when `op_sub`=1, for both values of `is_signed`.
- R4: With `is_signed`=0, `cb` is the carry out of bit 9 on addition (sum above 1023). On subtraction it is the borrow (opa < opb as unsigned values).
- R5: With `is_signed`=1, `cb` is 0.
- R6: With `is_signed`=0, `ovf` is 0.
- R7: With `is_signed`=1, `ovf` is 1 exactly when the true signed sum or difference falls outside -512..+511.
- R8: With `is_signed`=0, `gt` and `lt` follow the unsigned ordering of `opa` and `opb`.
- R9: With `is_signed`=1, `gt` and `lt` follow the two's-complement ordering, with bit 9 as the sign.
- R10: Exactly one of `gt`, `eq` and `lt` is 1. `eq` is 1 exactly when the two bit patterns are identical, whatever the value of `is_signed`.
- R11: The lookahead/grouped build and the ripple/ripple build give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_signed | input | 1 | 0 = unsigned operands, 1 = two's-complement operands |
| op_sub | input | 1 | 0 = add, 1 = subtract (opa - opb) |
| opa | input | 10 | First operand |
| opb | input | 10 | Second operand |
| res | output | 10 | Registered sum or difference |
| cb | output | 1 | Unsigned carry (add) or borrow (subtract) |
| ovf | output | 1 | Signed overflow |
| gt | output | 1 | opa greater than opb |
| eq | output | 1 | opa equal to opb |
| lt | output | 1 | opa less than opb |

## Verification
Some properties are checked by assertions on every cycle:
- The three compare flags stay one-hot.
- The unused flag stays low for each type.
- The borrow matches the unsigned order of the previous operands.
- The result matches the modular sum or difference.
- The flags follow the ordering of the sampled inputs in both types.

Other behaviour shows up only in the bench scenarios. These are the exact position of the signed overflow at the -512/+511 limits and the carry at the 1023 boundary. The bench also compares the two internal architectures against each other, and checks the reset values and the one-edge timing.

// File: rtl/dtau_pkg.sv
package dtau_pkg;

  typedef enum logic {
    ADD_RIPPLE    = 1'b0,
    ADD_LOOKAHEAD = 1'b1
  } add_arch_e;

  typedef enum logic {
    CMP_RIPPLE = 1'b0,
    CMP_GROUP  = 1'b1
  } cmp_arch_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmp_flags_t;

  localparam int unsigned GROUP_W = 4;

endpackage

// File: rtl/dtau_cmp_cell.sv
// Small magnitude compare cell: flat equality-prefix equations.
module dtau_cmp_cell #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  output logic          gt,
  output logic          lt
);
  logic [GW-1:0] same;
  assign same = ~(a ^ b);

  always_comb begin
    gt = 1'b0;
    lt = 1'b0;
    for (int k = 0; k < GW; k++) begin
      logic upper_same;
      upper_same = 1'b1;
      for (int j = k + 1; j < GW; j++) begin
        upper_same = upper_same & same[j];
      end
      gt = gt | (upper_same & a[k] & ~b[k]);
      lt = lt | (upper_same & ~a[k] & b[k]);
    end
  end
endmodule

// File: rtl/dtau_cmp.sv
// Magnitude comparator shared by both data types.
module dtau_cmp
  import dtau_pkg::*;
#(
  parameter int unsigned W    = 10,
  parameter cmp_arch_e   ARCH = CMP_GROUP
) (
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmp_flags_t   flags
);
  localparam logic [W-1:0] SIGN_MASK = {1'b1, {(W-1){1'b0}}};
  localparam int unsigned  NG        = (W + GROUP_W - 1) / GROUP_W;

  logic [W-1:0] xa, xb;
  logic         is_gt, is_lt;

  // Flipping both sign bits maps signed order onto unsigned order.
  assign xa = a ^ (is_signed ? SIGN_MASK : '0);
  assign xb = b ^ (is_signed ? SIGN_MASK : '0);

  generate
    if (ARCH == CMP_RIPPLE) begin : g_ripple
      logic [W:0] gch, lch;
      assign gch[W] = 1'b0;
      assign lch[W] = 1'b0;
      for (genvar i = W - 1; i >= 0; i--) begin : g_bit
        assign gch[i] = gch[i+1] | (~lch[i+1] & xa[i] & ~xb[i]);
        assign lch[i] = lch[i+1] | (~gch[i+1] & ~xa[i] & xb[i]);
      end
      assign is_gt = gch[0];
      assign is_lt = lch[0];
    end else begin : g_group
      logic [NG-1:0] grp_gt, grp_lt;
      for (genvar gi = 0; gi < NG; gi++) begin : g_cell
        localparam int unsigned LO  = gi * GROUP_W;
        localparam int unsigned GWI = ((W - LO) < GROUP_W) ? (W - LO) : GROUP_W;
        dtau_cmp_cell #(.GW(GWI)) u_cell (
          .a  (xa[LO +: GWI]),
          .b  (xb[LO +: GWI]),
          .gt (grp_gt[gi]),
          .lt (grp_lt[gi])
        );
      end
      always_comb begin
        is_gt = 1'b0;
        is_lt = 1'b0;
        for (int g = NG - 1; g >= 0; g--) begin
          if (!is_gt && !is_lt) begin
            is_gt = grp_gt[g];
            is_lt = grp_lt[g];
          end
        end
      end
    end
  endgenerate

  assign flags.gt = is_gt;
  assign flags.lt = is_lt;
  assign flags.eq = ~is_gt & ~is_lt;
endmodule

// File: rtl/dtau_cla_group.sv
// Lookahead carries for one group; all carries depend directly on ci.
module dtau_cla_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] p,
  input  logic [GW-1:0] g,
  input  logic          ci,
  output logic [GW:1]   c
);
  always_comb begin
    for (int k = 1; k <= GW; k++) begin
      logic acc;
      logic prop;
      prop = 1'b1;
      for (int j = 0; j < k; j++) prop = prop & p[j];
      acc = prop & ci;
      for (int j = 0; j < k; j++) begin
        logic run;
        run = g[j];
        for (int m = j + 1; m < k; m++) run = run & p[m];
        acc = acc | run;
      end
      c[k] = acc;
    end
  end
endmodule

// File: rtl/dtau_addsub.sv
// Adder/subtractor: A + (B xor sub) + sub.
module dtau_addsub
  import dtau_pkg::*;
#(
  parameter int unsigned W    = 10,
  parameter add_arch_e   ARCH = ADD_LOOKAHEAD
) (
  input  logic         op_sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf_raw
);
  localparam int unsigned NG = (W + GROUP_W - 1) / GROUP_W;

  logic [W-1:0] bx, pr, gn;
  logic [W:0]   c;

  assign bx   = b ^ {W{op_sub}};
  assign pr   = a ^ bx;
  assign gn   = a & bx;
  assign c[0] = op_sub;

  generate
    if (ARCH == ADD_RIPPLE) begin : g_ripple
      for (genvar i = 0; i < W; i++) begin : g_fa
        assign c[i+1] = gn[i] | (pr[i] & c[i]);
      end
    end else begin : g_cla
      for (genvar gi = 0; gi < NG; gi++) begin : g_grp
        localparam int unsigned LO  = gi * GROUP_W;
        localparam int unsigned GWI = ((W - LO) < GROUP_W) ? (W - LO) : GROUP_W;
        dtau_cla_group #(.GW(GWI)) u_grp (
          .p  (pr[LO +: GWI]),
          .g  (gn[LO +: GWI]),
          .ci (c[LO]),
          .c  (c[LO+GWI:LO+1])
        );
      end
    end
  endgenerate

  assign sum     = pr ^ c[W-1:0];
  assign cout    = c[W];
  assign ovf_raw = (a[W-1] == bx[W-1]) & (sum[W-1] != a[W-1]);
endmodule

// File: rtl/dtype_arith_unit.sv
module dtype_arith_unit
  import dtau_pkg::*;
#(
  parameter int unsigned W        = 10,
  parameter add_arch_e   ADD_ARCH = ADD_LOOKAHEAD,
  parameter cmp_arch_e   CMP_ARCH = CMP_GROUP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         is_signed,
  input  logic         op_sub,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res,
  output logic         cb,
  output logic         ovf,
  output logic         gt,
  output logic         eq,
  output logic         lt
);
  logic [W-1:0] sum_c;
  logic         cout_c, ovf_c;
  cmp_flags_t   cmp_c;

  dtau_addsub #(.W(W), .ARCH(ADD_ARCH)) u_addsub (
    .op_sub  (op_sub),
    .a       (opa),
    .b       (opb),
    .sum     (sum_c),
    .cout    (cout_c),
    .ovf_raw (ovf_c)
  );

  dtau_cmp #(.W(W), .ARCH(CMP_ARCH)) u_cmp (
    .is_signed (is_signed),
    .a         (opa),
    .b         (opb),
    .flags     (cmp_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
      cb  <= 1'b0;
      ovf <= 1'b0;
      gt  <= 1'b0;
      eq  <= 1'b1;
      lt  <= 1'b0;
    end else begin
      res <= sum_c;
      cb  <= ~is_signed & (cout_c ^ op_sub);
      ovf <= is_signed & ovf_c;
      gt  <= cmp_c.gt;
      eq  <= cmp_c.eq;
      lt  <= cmp_c.lt;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $countones({gt, eq, lt}) == 1); // R10
  AST_EQ_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (opa == opb) |=> eq); // R10
  AST_SUM_VALUE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> res == ($past(op_sub) ? W'($past(opa) - $past(opb))
                                   : W'($past(opa) + $past(opb)))); // R3
  AST_BORROW: assert property (@(posedge clk) disable iff (rst)
    (!is_signed && op_sub) |=> cb == ($past(opa) < $past(opb))); // R4
  AST_NO_CB_SIGNED: assert property (@(posedge clk) disable iff (rst)
    is_signed |=> !cb); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !is_signed |=> !ovf); // R6
  AST_UNSIGNED_ORDER: assert property (@(posedge clk) disable iff (rst)
    (!is_signed && opa > opb) |=> gt); // R8
  AST_SIGNED_ORDER: assert property (@(posedge clk) disable iff (rst)
    (is_signed && ($signed(opa) < $signed(opb))) |=> lt); // R9
endmodule

// File: tb/dtype_arith_unit_tb.sv
`timescale 1ns/1ps
module dtype_arith_unit_tb;
  import dtau_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       is_signed = 1'b0, op_sub = 1'b0;
  logic [9:0] opa = '0, opb = '0;
  logic [9:0] res, res2;
  logic       cb, ovf, gt, eq, lt, cb2, ovf2, gt2, eq2, lt2;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  dtype_arith_unit u_dut (
    .clk(clk), .rst(rst), .is_signed(is_signed), .op_sub(op_sub),
    .opa(opa), .opb(opb), .res(res), .cb(cb), .ovf(ovf),
    .gt(gt), .eq(eq), .lt(lt));

  dtype_arith_unit #(.ADD_ARCH(ADD_RIPPLE), .CMP_ARCH(CMP_RIPPLE)) u_alt (
    .clk(clk), .rst(rst), .is_signed(is_signed), .op_sub(op_sub),
    .opa(opa), .opb(opb), .res(res2), .cb(cb2), .ovf(ovf2),
    .gt(gt2), .eq(eq2), .lt(lt2));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sval(input logic [9:0] v);
    return (v >= 10'd512) ? int'(v) - 1024 : int'(v);
  endfunction

  task automatic apply(input int a, input int b, input bit sgn, input bit sub);
    int ua, ub, sa, sb, r, sr, exp_res, exp_cb, exp_ovf, exp_cmp, act_cmp;
    logic [9:0] old_res;
    @(negedge clk);
    old_res   = res;
    opa       = 10'(a);
    opb       = 10'(b);
    is_signed = sgn;
    op_sub    = sub;
    #1;
    check(res == old_res, "R2 output held before edge", res, old_res);
    @(negedge clk);
    ua = int'(opa); ub = int'(opb); sa = sval(opa); sb = sval(opb);
    r  = sub ? ua - ub : ua + ub;
    sr = sub ? sa - sb : sa + sb;
    exp_res = r & 1023;
    exp_cb  = sgn ? 0 : (sub ? int'(ua < ub) : int'(r > 1023));
    exp_ovf = sgn ? int'(sr > 511 || sr < -512) : 0;
    if (sgn) exp_cmp = (sa > sb) ? 4 : (sa == sb) ? 2 : 1;
    else     exp_cmp = (ua > ub) ? 4 : (ua == ub) ? 2 : 1;
    act_cmp = {gt, eq, lt};
    check(int'(res) == exp_res, "R3 result", res, exp_res);
    check(int'(cb) == exp_cb, sgn ? "R5 cb signed" : "R4 carry/borrow", cb, exp_cb);
    check(int'(ovf) == exp_ovf, sgn ? "R7 overflow" : "R6 ovf unsigned", ovf, exp_ovf);
    check(act_cmp == exp_cmp, sgn ? "R9 R10 signed compare" : "R8 R10 unsigned compare",
          act_cmp, exp_cmp);
    check({res2, cb2, ovf2, gt2, eq2, lt2} == {res, cb, ovf, gt, eq, lt},
          "R11 architectures agree", {res2, cb2, ovf2, gt2, eq2, lt2},
          {res, cb, ovf, gt, eq, lt});
  endtask

  int uvals [9] = '{987, 345, 23, 1, 0, 14, 1023, 512, 511};
  int svals [11] = '{33, -33, 510, -510, 92, -39, 0, -512, 511, -1, 1};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check({res, cb, ovf, gt, eq, lt} == 15'b0000000000_00_010, "R1 reset state",
          {res, cb, ovf, gt, eq, lt}, 2);
    rst = 1'b0;
    foreach (uvals[i]) foreach (uvals[j]) for (int s = 0; s < 2; s++)
      apply(uvals[i], uvals[j], 1'b0, s[0]);
    foreach (svals[i]) foreach (svals[j]) for (int s = 0; s < 2; s++)
      apply(svals[i], svals[j], 1'b1, s[0]);
    // R10: identical pattern reads equal in both types
    apply(700, 700, 1'b0, 1'b0);
    apply(700, 700, 1'b1, 1'b1);
    for (int k = 0; k < 3000; k++)
      apply(int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    // R1: reset again from nonzero state
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check({res, cb, ovf, gt, eq, lt} == 15'b0000000000_00_010, "R1 reset again",
          {res, cb, ovf, gt, eq, lt}, 2);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule